// File: doc/BRIEF.md
# Rename Stall Controller

This block is the control state machine for one thread of a superscalar rename stage. Each cycle it decides how many of the incoming decoded instructions may be renamed. It can also hold them back in a skid buffer, or wait out a serializing instruction. The decision is driven by the free space left in the reorder buffer (ROB), the issue queue (IQ) and the load/store queue (LSQ), and by the free physical register count. Stall requests from the execute and commit stages, squash requests, and the reorder-buffer-empty flag also feed into it.

The skid buffer storage, the map table and the datapath live outside this block. It keeps only the skid occupancy. It also keeps an in-flight counter: instructions already handed to the ROB and IQ whose entries the downstream free counts do not yet reflect. It reports four things:

- the current state;
- a block signal sent back toward decode;
- the number of instructions renamed this cycle;
- a stall-cause code for the structure that filled.

Top module: `rn_stall_ctrl`

## Requirements
- R1: Reset puts the controller in Idle (code 1), with block_up low, the skid occupancy and in-flight count cleared, and ren_cnt 0.
- R2: In Running (0) or Idle (1), with no stall, no serialize flag and no squash, ren_cnt equals in_cnt capped at WIDTH. The next state is Running, or Idle when in_cnt is 0.
- R3: The demand is the number of instructions about to be renamed. A structure is full when its effective free count is below the demand. stall_cause reports 0 for ROB, 1 for IQ, 2 for LSQ, and 3 when none is full. ROB wins over IQ, and IQ wins over LSQ.
- R4: The effective ROB and IQ free counts are the input counts minus the in-flight count, floored at 0. Each cycle the in-flight count gains ren_cnt and loses ack_cnt, floored at 0.
- R5: exec_stall or commit_stall, either one alone, forces ren_cnt to 0. From Running or Idle, the inputs go to the skid and the next state is Blocked (4). In Blocked, the controller stays there.
- R6: reg_short is 1 when phys_free is below the demand. It stops renaming like a full structure but leaves stall_cause unchanged.
- R7: Blocked moves to Unblocking (5) once no stall applies to the skid demand. Unblocking renames up to WIDTH skid entries a cycle and appends new inputs to the skid. It returns to Running when the skid empties. block_up is 1 whenever the skid is non-empty or the state is Blocked or SerializeStall.
- R8: When a slot below in_cnt carries a serialize flag (bit i for slot i), only the older slots are renamed and the rest go to the skid. The state becomes SerializeStall (6). It stays there until rob_empty is high and the in-flight count is 0, then moves to Unblocking.
- R9: A squash in any state gives ren_cnt 0 and StartSquash (2) next. StartSquash clears the skid and in-flight count and moves to Squashing (3), or stays in StartSquash if squash is still high. Squashing renames nothing and moves to Running when in_cnt is non-zero, otherwise to Idle.
- R10: The skid occupancy saturates at SKID_DEPTH. A full skid drains in exactly SKID_DEPTH/WIDTH Unblocking cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| squash | input | 1 | Squash request |
| exec_stall | input | 1 | Stall request from execute |
| commit_stall | input | 1 | Stall request from commit |
| in_cnt | input | $clog2(WIDTH+1) | Valid instructions arriving from decode |
| in_ser | input | WIDTH | Per-slot serialize flags |
| rob_free | input | CNT_W | Reported free ROB entries |
| iq_free | input | CNT_W | Reported free IQ entries |
| lsq_free | input | CNT_W | Reported free LSQ entries |
| phys_free | input | CNT_W | Free physical registers |
| ack_cnt | input | CNT_W | Entries newly counted downstream this cycle |
| rob_empty | input | 1 | Reorder buffer is empty |
| state | output | 3 | Current state code |
| block_up | output | 1 | Block request toward decode |
| ren_cnt | output | $clog2(WIDTH+1) | Instructions renamed this cycle |
| stall_cause | output | 2 | Full-structure cause code |
| reg_short | output | 1 | Physical register shortage |

## Verification
The bench covers these corner cases:

- **Several full structures at once.** A design with the wrong priority reports IQ or LSQ where ROB or IQ belongs.
- **Acknowledgements larger than the in-flight count.** A wrapping counter would then starve the ROB and block a later rename that should pass.
- **A serialize flag in slot 0, and one in the middle.** A design that left SerializeStall on rob_empty alone would exit while instructions were still in flight.
- **Back-to-back squashes.** A design that cleared nothing, or deasserted block_up before the skid drained, would show up here.
- **A skid pushed past its depth.** A design without saturation would need an extra drain cycle before returning to Running.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_SQ_START = 3'd2,
        ST_SQ_BUSY  = 3'd3,
        ST_BLOCKED  = 3'd4,
        ST_UNBLOCK  = 3'd5,
        ST_SER_WAIT = 3'd6
    } rn_state_e;

    // Order of codes matches report priority: lower code wins
    typedef enum logic [1:0] {
        CAUSE_ROB  = 2'd0,
        CAUSE_IQ   = 2'd1,
        CAUSE_LSQ  = 2'd2,
        CAUSE_NONE = 2'd3
    } rn_cause_e;

endpackage

// File: rtl/rn_sat_sub.sv
module rn_sat_sub #(
    parameter int W = 6
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        y = (a > b) ? (a - b) : '0;
    end
endmodule

// File: rtl/rn_first_flag.sv
module rn_first_flag #(
    parameter int WIDTH = 4,
    parameter int CW    = 3
) (
    input  logic [WIDTH-1:0] flags,
    input  logic [CW-1:0]    count,
    output logic             hit,
    output logic [CW-1:0]    idx
);
    // Lowest valid slot carrying a flag; slots at or above count are ignored
    always_comb begin
        hit = 1'b0;
        idx = CW'(WIDTH);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (flags[i] && (CW'(i) < count)) begin
                hit = 1'b1;
                idx = CW'(i);
            end
        end
    end
endmodule

// File: rtl/rn_full_pick.sv
module rn_full_pick
    import rn_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int CW    = 3
) (
    input  logic [CW-1:0]    demand,
    input  logic [CNT_W-1:0] rob_eff,
    input  logic [CNT_W-1:0] iq_eff,
    input  logic [CNT_W-1:0] lsq_free,
    input  logic [CNT_W-1:0] phys_free,
    output rn_cause_e        cause,
    output logic             reg_short
);
    logic [CNT_W-1:0] dem_x;

    always_comb begin
        dem_x     = CNT_W'(demand);
        reg_short = (phys_free < dem_x);
        if (rob_eff < dem_x)       cause = CAUSE_ROB;
        else if (iq_eff < dem_x)   cause = CAUSE_IQ;
        else if (lsq_free < dem_x) cause = CAUSE_LSQ;
        else                       cause = CAUSE_NONE;
    end
endmodule

// File: rtl/rn_stall_ctrl.sv
module rn_stall_ctrl
    import rn_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int CNT_W      = 6,
    parameter int SKID_DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         squash,
    input  logic                         exec_stall,
    input  logic                         commit_stall,
    input  logic [$clog2(WIDTH+1)-1:0]   in_cnt,
    input  logic [WIDTH-1:0]             in_ser,
    input  logic [CNT_W-1:0]             rob_free,
    input  logic [CNT_W-1:0]             iq_free,
    input  logic [CNT_W-1:0]             lsq_free,
    input  logic [CNT_W-1:0]             phys_free,
    input  logic [CNT_W-1:0]             ack_cnt,
    input  logic                         rob_empty,
    output logic [2:0]                   state,
    output logic                         block_up,
    output logic [$clog2(WIDTH+1)-1:0]   ren_cnt,
    output logic [1:0]                   stall_cause,
    output logic                         reg_short
);
    localparam int CW  = $clog2(WIDTH + 1);
    localparam int SKW = $clog2(SKID_DEPTH + 1);

    typedef struct packed {
        rn_state_e        st;
        logic [SKW-1:0]   skid;
        logic [CNT_W-1:0] infl;
    } ctl_t;

    ctl_t q, d;

    logic [CW-1:0]    in_eff, skid_cap, demand, ser_idx, ren;
    logic             ser_hit, short_w, stall_any;
    logic [CNT_W-1:0] rob_eff, iq_eff;
    rn_cause_e        cause;

    function automatic logic [SKW-1:0] skid_add(input logic [SKW-1:0] base,
                                                input logic [CW-1:0]  add);
        logic [SKW:0] s;
        s = {1'b0, base} + (SKW+1)'(add);
        if (s > (SKW+1)'(SKID_DEPTH)) return SKW'(SKID_DEPTH);
        return s[SKW-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] infl_next(input logic [CNT_W-1:0] cur,
                                                   input logic [CW-1:0]    add,
                                                   input logic [CNT_W-1:0] sub);
        logic [CNT_W:0] s, a;
        s = {1'b0, cur} + (CNT_W+1)'(add);
        a = {1'b0, sub};
        if (s <= a) return '0;
        s = s - a;
        if (s[CNT_W]) return '1;
        return s[CNT_W-1:0];
    endfunction

    // In-flight entries are hidden from the ROB and IQ counts
    rn_sat_sub #(.W(CNT_W)) u_rob_eff (.a(rob_free), .b(q.infl), .y(rob_eff));
    rn_sat_sub #(.W(CNT_W)) u_iq_eff  (.a(iq_free),  .b(q.infl), .y(iq_eff));

    rn_first_flag #(.WIDTH(WIDTH), .CW(CW)) u_ser (
        .flags (in_ser),
        .count (in_eff),
        .hit   (ser_hit),
        .idx   (ser_idx)
    );

    rn_full_pick #(.CNT_W(CNT_W), .CW(CW)) u_pick (
        .demand    (demand),
        .rob_eff   (rob_eff),
        .iq_eff    (iq_eff),
        .lsq_free  (lsq_free),
        .phys_free (phys_free),
        .cause     (cause),
        .reg_short (short_w)
    );

    // Demand: how many instructions this state would rename now
    always_comb begin
        in_eff   = (in_cnt > CW'(WIDTH)) ? CW'(WIDTH) : in_cnt;
        skid_cap = (q.skid >= SKW'(WIDTH)) ? CW'(WIDTH) : CW'(q.skid);
        demand   = '0;
        if (!squash) begin
            case (q.st)
                ST_RUN, ST_IDLE:         demand = ser_hit ? ser_idx : in_eff;
                ST_BLOCKED, ST_UNBLOCK:  demand = skid_cap;
                default:                 demand = '0;
            endcase
        end
        stall_any = exec_stall | commit_stall | short_w | (cause != CAUSE_NONE);
    end

    // Next-state computation
    always_comb begin
        d   = q;
        ren = '0;
        if (squash) begin
            d.st = ST_SQ_START;
        end else begin
            case (q.st)
                ST_RUN, ST_IDLE: begin
                    if (stall_any) begin
                        d.skid = skid_add(q.skid, in_eff);
                        d.st   = ST_BLOCKED;
                    end else begin
                        ren = demand;
                        if (ser_hit) begin
                            d.skid = skid_add(q.skid, in_eff - demand);
                            d.st   = ST_SER_WAIT;
                        end else begin
                            d.st = (in_eff == '0) ? ST_IDLE : ST_RUN;
                        end
                    end
                end
                ST_BLOCKED: begin
                    d.skid = skid_add(q.skid, in_eff);
                    if (!stall_any) d.st = ST_UNBLOCK;
                end
                ST_UNBLOCK: begin
                    if (stall_any) begin
                        d.skid = skid_add(q.skid, in_eff);
                        d.st   = ST_BLOCKED;
                    end else begin
                        ren    = demand;
                        d.skid = skid_add(q.skid - SKW'(demand), in_eff);
                        if (d.skid == '0) d.st = ST_RUN;
                    end
                end
                ST_SER_WAIT: begin
                    d.skid = skid_add(q.skid, in_eff);
                    if (rob_empty && (q.infl == '0)) d.st = ST_UNBLOCK;
                end
                ST_SQ_START: d.st = ST_SQ_BUSY;
                ST_SQ_BUSY:  d.st = (in_eff != '0) ? ST_RUN : ST_IDLE;
                default:     d.st = ST_IDLE;
            endcase
        end
        d.infl = infl_next(q.infl, ren, ack_cnt);
        if (q.st == ST_SQ_START) begin
            d.skid = '0;
            d.infl = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.skid <= '0;
            q.infl <= '0;
        end else begin
            q <= d;
        end
    end

    assign state       = q.st;
    assign block_up    = (q.skid != '0) || (q.st == ST_BLOCKED) || (q.st == ST_SER_WAIT);
    assign ren_cnt     = ren;
    assign stall_cause = cause;
    assign reg_short   = short_w;

endmodule

// File: rtl/rn_stall_ctrl_chk.sv
module rn_stall_ctrl_chk
    import rn_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int CNT_W      = 6,
    parameter int SKID_DEPTH = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        squash,
    input logic                        exec_stall,
    input logic                        commit_stall,
    input logic                        rob_empty,
    input logic [2:0]                  state,
    input logic                        block_up,
    input logic [$clog2(WIDTH+1)-1:0]  ren_cnt,
    input logic [1:0]                  stall_cause,
    input logic                        reg_short,
    input logic [$clog2(SKID_DEPTH+1)-1:0] skid
);
    a_r2_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ren_cnt <= ($clog2(WIDTH+1))'(WIDTH));

    a_r3_rename_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_cnt != '0) |-> (stall_cause == 2'd3 && !reg_short));

    a_r5_ext_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stall || commit_stall) |-> (ren_cnt == '0));

    a_r7_run_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'(ST_RUN)) |-> !block_up);

    a_r8_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'(ST_SER_WAIT) && !rob_empty && !squash) |=> (state == 3'(ST_SER_WAIT)));

    a_r8_ser_no_rename: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'(ST_SER_WAIT)) |-> (ren_cnt == '0));

    a_r9_squash_enter: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (state == 3'(ST_SQ_START)));

    a_r9_squash_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'(ST_SQ_START)) |=> (skid == '0));

    a_r10_skid_bound: assert property (@(posedge clk) disable iff (!rst_n)
        skid <= ($clog2(SKID_DEPTH+1))'(SKID_DEPTH));
endmodule

bind rn_stall_ctrl rn_stall_ctrl_chk #(
    .WIDTH(WIDTH), .CNT_W(CNT_W), .SKID_DEPTH(SKID_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .squash       (squash),
    .exec_stall   (exec_stall),
    .commit_stall (commit_stall),
    .rob_empty    (rob_empty),
    .state        (state),
    .block_up     (block_up),
    .ren_cnt      (ren_cnt),
    .stall_cause  (stall_cause),
    .reg_short    (reg_short),
    .skid         (q.skid)
);

// File: tb/rn_stall_ctrl_tb.sv
module rn_stall_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       squash = 0, exec_stall = 0, commit_stall = 0, rob_empty = 0;
    logic [2:0] in_cnt = '0;
    logic [3:0] in_ser = '0;
    logic [5:0] rob_free = 20, iq_free = 20, lsq_free = 20, phys_free = 20, ack_cnt = 0;
    logic [2:0] state;
    logic       block_up;
    logic [2:0] ren_cnt;
    logic [1:0] stall_cause;
    logic       reg_short;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rn_stall_ctrl #(.WIDTH(4), .CNT_W(6), .SKID_DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .squash(squash), .exec_stall(exec_stall),
        .commit_stall(commit_stall), .in_cnt(in_cnt), .in_ser(in_ser),
        .rob_free(rob_free), .iq_free(iq_free), .lsq_free(lsq_free),
        .phys_free(phys_free), .ack_cnt(ack_cnt), .rob_empty(rob_empty),
        .state(state), .block_up(block_up), .ren_cnt(ren_cnt),
        .stall_cause(stall_cause), .reg_short(reg_short)
    );

    typedef struct packed {
        logic       sq, es, cs;
        logic [2:0] inc;
        logic [3:0] ser;
        logic [5:0] rob, iq, lsq, phys, ack;
        logic       re;
        logic [2:0] ren;
        logic [1:0] cause;
        logic       sh;
        logic [2:0] st;
        logic       blk;
    } vec_t;

    localparam int NV = 42;
    // sq es cs in ser rob iq lsq phys ack re | ren cause short state_after block_after
    localparam vec_t VECS [NV] = '{
        '{0,0,0,3,4'b0000,20,20,20,20,0,0, 3,3,0,0,0}, // 0  R2 idle->run
        '{0,0,0,4,4'b0000, 6,20,20,20,0,0, 0,0,0,4,1}, // 1  R4 rob 6-3 < 4
        '{0,0,0,2,4'b0000,20,20,20,20,3,0, 0,3,0,5,1}, // 2  R7 blocked->unblock
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 4,3,0,5,1}, // 3  R7 drain 4
        '{0,0,0,1,4'b0000,20, 5, 0,20,0,0, 0,1,0,4,1}, // 4  R3 IQ beats LSQ
        '{0,1,0,0,4'b0000,20,20,20,20,4,0, 0,3,0,4,1}, // 5  R5 exec stall
        '{0,0,1,0,4'b0000,20,20,20,20,0,0, 0,3,0,4,1}, // 6  R5 commit stall
        '{0,0,0,0,4'b0000,20,20, 2,20,0,0, 0,2,0,4,1}, // 7  R3 LSQ only
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,5,1}, // 8  R7
        '{0,0,0,0,4'b0000,20,20,20, 2,0,0, 0,3,1,4,1}, // 9  R6 reg shortage
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,5,1}, // 10 R7
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 3,3,0,0,0}, // 11 R7 skid empty -> run
        '{0,0,0,4,4'b0100,20,20,20,20,0,0, 2,3,0,6,1}, // 12 R8 serialize slot 2
        '{0,0,0,0,4'b0000,20,20,20,20,0,1, 0,3,0,6,1}, // 13 R8 in flight
        '{0,0,0,0,4'b0000,20,20,20,20,5,0, 0,3,0,6,1}, // 14 R8 rob not empty
        '{0,0,0,0,4'b0000,20,20,20,20,0,1, 0,3,0,5,1}, // 15 R8 exit
        '{0,0,0,1,4'b0000,20,20,20,20,0,0, 2,3,0,5,1}, // 16 R7 append
        '{1,0,0,2,4'b0000,20,20,20,20,0,0, 0,3,0,2,1}, // 17 R9 squash
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,3,0}, // 18 R9 clears skid
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,1,0}, // 19 R9 -> idle
        '{0,0,0,4,4'b0001,20,20,20,20,0,0, 0,3,0,6,1}, // 20 R8 serialize slot 0
        '{0,0,0,0,4'b0000,20,20,20,20,0,1, 0,3,0,5,1}, // 21 R8
        '{0,0,0,0,4'b0000, 3, 0,20,20,0,0, 0,0,0,4,1}, // 22 R3 ROB beats IQ
        '{1,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,2,1}, // 23 R9
        '{1,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,2,0}, // 24 R9 repeat squash
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,3,0}, // 25 R9
        '{0,0,0,2,4'b0000,20,20,20,20,0,0, 0,3,0,0,0}, // 26 R9 squashing -> run
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,1,0}, // 27 R2 run -> idle
        '{0,0,0,2,4'b0000,20,20,20,20,5,0, 2,3,0,0,0}, // 28 R4 ack floor
        '{0,0,0,4,4'b0000, 4, 4,20,20,0,0, 4,3,0,0,0}, // 29 R4 count was floored
        '{0,0,0,1,4'b0000, 4,20,20,20,0,0, 0,0,0,4,1}, // 30 R4 rob 4-4 < 1
        '{0,1,0,4,4'b0000,20,20,20,20,0,0, 0,3,0,4,1}, // 31 R10 fill
        '{0,1,0,4,4'b0000,20,20,20,20,0,0, 0,3,0,4,1}, // 32 R10
        '{0,1,0,4,4'b0000,20,20,20,20,0,0, 0,3,0,4,1}, // 33 R10
        '{0,1,0,4,4'b0000,20,20,20,20,0,0, 0,3,0,4,1}, // 34 R10 saturate
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,5,1}, // 35 R10
        '{0,0,0,0,4'b0000,20,20,20,20,4,0, 4,3,0,5,1}, // 36 R10 drain
        '{0,0,0,0,4'b0000,20,20,20,20,4,0, 4,3,0,5,1}, // 37 R10
        '{0,0,0,0,4'b0000,20,20,20,20,4,0, 4,3,0,5,1}, // 38 R10
        '{0,0,0,0,4'b0000,20,20,20,20,4,0, 4,3,0,0,0}, // 39 R10 empty after 4
        '{0,0,0,0,4'b0000,20,20,20,20,0,0, 0,3,0,1,0}, // 40 R2
        '{0,0,0,7,4'b0000,20,20,20,20,0,0, 4,3,0,0,0}  // 41 R2 cap at width
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input int idx);
        squash = v.sq; exec_stall = v.es; commit_stall = v.cs;
        in_cnt = v.inc; in_ser = v.ser;
        rob_free = v.rob; iq_free = v.iq; lsq_free = v.lsq;
        phys_free = v.phys; ack_cnt = v.ack; rob_empty = v.re;
        #1;
        chk("R2", $sformatf("ren_cnt v%0d", idx), ren_cnt, v.ren);
        chk("R3", $sformatf("stall_cause v%0d", idx), stall_cause, v.cause);
        chk("R6", $sformatf("reg_short v%0d", idx), reg_short, v.sh);
        @(posedge clk); #1;
        chk("R7", $sformatf("state v%0d", idx), state, v.st);
        chk("R7", $sformatf("block_up v%0d", idx), block_up, v.blk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1", "state in reset", state, 1);
        chk("R1", "block_up in reset", block_up, 0);
        chk("R1", "ren_cnt in reset", ren_cnt, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(VECS[i], i);

        // R1: reset mid-run clears in-flight count (8 entries pending here)
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", "state after mid reset", state, 1);
        chk("R1", "block_up after mid reset", block_up, 0);
        @(negedge clk);
        rst_n = 1'b1;
        squash = 0; exec_stall = 0; commit_stall = 0; in_ser = '0;
        in_cnt = 1; rob_free = 1; iq_free = 1; lsq_free = 20; phys_free = 20; ack_cnt = 0;
        #1;
        chk("R1", "rename with cleared in-flight", ren_cnt, 1);
        chk("R4", "cause with cleared in-flight", stall_cause, 3);
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule